// File: doc/BRIEF.md
# Flash Status Register and Sector Protection

This block keeps the status byte of a serial flash memory. The byte carries a busy flag that is set while a program or erase cycle runs, a write-enable latch, and a three-bit protect code. A command decoder upstream sends one-cycle event strobes and the target sector number. The events are: latch set, latch clear, status write, page program, sector erase and bulk erase. For each program, erase or status write, the block answers with a one-cycle grant or refuse pulse.

A granted operation starts an internal down-counter that stands in for the length of the cycle. While the counter runs the busy flag reads 1. The busy flag falls when the count is done, and at that moment the latch clears. The protect code marks a share of the upper sectors as locked, as a fraction of a power-of-two sector count (32 sectors by default). Bulk erase runs only when the protect code is zero. Non-volatile storage and the memory array are not part of this block.

Top module: `flash_status_prot`

## Requirements
- R1: `statusOut` bit 0 is the busy flag, bit 1 is the write-enable latch, bits 4..2 hold the protect code (bit 4 = most significant), and bits 7..5 read 0. After reset the whole byte is 0.
- R2: When idle, a latch-set event makes bit 1 read 1 and a latch-clear event makes it read 0. Both take effect one clock after the event.
- R3: When the latch is 0, a program, sector erase, bulk erase or status write is refused. The refusal changes no status bit.
- R4: A granted operation raises the busy flag one clock after its event. The flag stays high for exactly the configured number of cycles: PROG_CYCLES, SECT_ERASE_CYCLES, BULK_ERASE_CYCLES or STATUS_WR_CYCLES.
- R5: The latch clears in the same clock in which the busy flag falls.
- R6: While busy, every event is ignored. This includes latch set and latch clear. No grant or refuse is issued and the status byte does not change.
- R7: A granted status write loads `newProt` into bits 4..2 one clock after its event.
- R8: A bulk erase with a nonzero protect code is refused, and the refusal clears the latch.
- R9: Protect code 0 locks no sector. Codes 1 to 5 lock the top SECTORS/32, /16, /8, /4 and /2 sectors. Codes 6 and 7 lock every sector. A sector is locked when its number is at least SECTORS minus the locked count.
- R10: A program or sector erase aimed at a locked sector is refused. The busy flag stays 0 and the latch clears.
- R11: `opGrant` and `opRefuse` are single-cycle pulses. They appear one clock after the event, in the cycle in which the busy flag or the latch change becomes visible.
- R12: When several events arrive together, only one acts. The order of precedence is bulk erase, sector erase, program, status write, latch clear, latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWrEn | input | 1 | Latch-set event |
| cmdWrDis | input | 1 | Latch-clear event |
| cmdWrStat | input | 1 | Status write event |
| cmdProg | input | 1 | Page program event |
| cmdSecErase | input | 1 | Sector erase event |
| cmdBulkErase | input | 1 | Bulk erase event |
| cmdSector | input | $clog2(SECTORS) | Target sector of a program or sector erase |
| newProt | input | 3 | Protect code carried by a status write |
| statusOut | output | 8 | Status byte |
| opGrant | output | 1 | Pulse: the operation was accepted |
| opRefuse | output | 1 | Pulse: the operation was rejected |

## Verification
The bench builds the block with 32 sectors and short cycle lengths: 3 for program, 5 for sector erase, 7 for bulk erase and 2 for status write. These lengths make each busy window short enough to count exactly. They also let the bench step through all eight protect codes and probe both sides of every lock boundary (sectors 31, 30, 28, 24, 16 and 0) in a short run. Because the lengths differ, the busy length shows which operation won when events arrive together.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
  localparam int BP_W = 3;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadBp;
    logic startBusy;
    logic endBusy;
  } srStrobe_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_BULK, OP_SECT, OP_PROG, OP_WRSR, OP_WRDI, OP_WREN
  } opKind_t;
endpackage

// File: rtl/flash_sr_dp.sv
module flash_sr_dp
  import flash_sr_pkg::*;
#(
  parameter int SECTORS = 32,
  localparam int SECT_W = $clog2(SECTORS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  srStrobe_t         strb,
  input  logic [BP_W-1:0]   newProt,
  input  logic [SECT_W-1:0] sector,
  output logic              wel,
  output logic              wip,
  output logic              bpAny,
  output logic              sectorLocked,
  output logic [7:0]        statusOut
);
  logic [BP_W-1:0] bp;
  logic [SECT_W:0] lockCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel <= 1'b0;
      wip <= 1'b0;
      bp  <= '0;
    end else begin
      if (strb.clrWel || strb.endBusy) wel <= 1'b0;
      else if (strb.setWel)            wel <= 1'b1;
      if (strb.startBusy)    wip <= 1'b1;
      else if (strb.endBusy) wip <= 1'b0;
      if (strb.loadBp) bp <= newProt;
    end
  end

  // Locked share of the upper sectors per protect code
  always_comb begin
    case (bp)
      3'd0:    lockCount = '0;
      3'd1:    lockCount = (SECT_W+1)'(SECTORS >> 5);
      3'd2:    lockCount = (SECT_W+1)'(SECTORS >> 4);
      3'd3:    lockCount = (SECT_W+1)'(SECTORS >> 3);
      3'd4:    lockCount = (SECT_W+1)'(SECTORS >> 2);
      3'd5:    lockCount = (SECT_W+1)'(SECTORS >> 1);
      default: lockCount = (SECT_W+1)'(SECTORS);
    endcase
  end

  assign sectorLocked = ({1'b0, sector} >= ((SECT_W+1)'(SECTORS) - lockCount));
  assign bpAny        = |bp;
  assign statusOut    = {3'b000, bp, wel, wip};

  // A cycle can only start from a set latch
  assert_start_needs_wel_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(wel));
  // Completion clears the latch
  assert_end_clears_wel_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);
  // Protect code changes only through an accepted status write
  assert_bp_change_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bp) |-> ($past(wel) && !$past(wip) && wip));
endmodule

// File: rtl/flash_sr_ctrl.sv
module flash_sr_ctrl
  import flash_sr_pkg::*;
#(
  parameter int PROG_CYCLES       = 8,
  parameter int SECT_ERASE_CYCLES = 20,
  parameter int BULK_ERASE_CYCLES = 40,
  parameter int STATUS_WR_CYCLES  = 6,
  localparam int MAX_A  = (PROG_CYCLES > SECT_ERASE_CYCLES) ? PROG_CYCLES : SECT_ERASE_CYCLES,
  localparam int MAX_B  = (BULK_ERASE_CYCLES > STATUS_WR_CYCLES) ? BULK_ERASE_CYCLES : STATUS_WR_CYCLES,
  localparam int MAX_L  = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int LEN_W  = $clog2(MAX_L + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdWrEn,
  input  logic      cmdWrDis,
  input  logic      cmdWrStat,
  input  logic      cmdProg,
  input  logic      cmdSecErase,
  input  logic      cmdBulkErase,
  input  logic      wel,
  input  logic      wip,
  input  logic      bpAny,
  input  logic      sectorLocked,
  output srStrobe_t strb,
  output logic      opGrant,
  output logic      opRefuse
);
  localparam logic [LEN_W-1:0] PROG_M1 = LEN_W'(PROG_CYCLES - 1);
  localparam logic [LEN_W-1:0] SECT_M1 = LEN_W'(SECT_ERASE_CYCLES - 1);
  localparam logic [LEN_W-1:0] BULK_M1 = LEN_W'(BULK_ERASE_CYCLES - 1);
  localparam logic [LEN_W-1:0] WRSR_M1 = LEN_W'(STATUS_WR_CYCLES - 1);

  opKind_t          op;
  logic [LEN_W-1:0] cnt, loadVal;
  logic             grantN, refuseN;

  always_comb begin
    if (cmdBulkErase)     op = OP_BULK;
    else if (cmdSecErase) op = OP_SECT;
    else if (cmdProg)     op = OP_PROG;
    else if (cmdWrStat)   op = OP_WRSR;
    else if (cmdWrDis)    op = OP_WRDI;
    else if (cmdWrEn)     op = OP_WREN;
    else                  op = OP_NONE;
  end

  always_comb begin
    strb    = '0;
    grantN  = 1'b0;
    refuseN = 1'b0;
    loadVal = '0;
    if (!wip) begin
      unique case (op)
        OP_BULK: begin
          if (!wel) refuseN = 1'b1;
          else if (bpAny) begin refuseN = 1'b1; strb.clrWel = 1'b1; end
          else begin grantN = 1'b1; strb.startBusy = 1'b1; loadVal = BULK_M1; end
        end
        OP_SECT, OP_PROG: begin
          if (!wel) refuseN = 1'b1;
          else if (sectorLocked) begin refuseN = 1'b1; strb.clrWel = 1'b1; end
          else begin
            grantN = 1'b1;
            strb.startBusy = 1'b1;
            loadVal = (op == OP_SECT) ? SECT_M1 : PROG_M1;
          end
        end
        OP_WRSR: begin
          if (!wel) refuseN = 1'b1;
          else begin
            grantN = 1'b1; strb.startBusy = 1'b1; strb.loadBp = 1'b1; loadVal = WRSR_M1;
          end
        end
        OP_WRDI: strb.clrWel = 1'b1;
        OP_WREN: strb.setWel = 1'b1;
        default: ;
      endcase
    end else if (cnt == '0) begin
      strb.endBusy = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      opGrant  <= 1'b0;
      opRefuse <= 1'b0;
    end else begin
      opGrant  <= grantN;
      opRefuse <= refuseN;
      if (strb.startBusy)           cnt <= loadVal;
      else if (wip && cnt != '0)    cnt <= cnt - 1'b1;
    end
  end

  // A refused operation never leaves a cycle running
  assert_refuse_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    opRefuse |-> !wip);
  // The timer only counts inside a busy window
  assert_timer_in_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |-> wip);
  // A grant always shows up together with a fresh busy window
  assert_grant_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    opGrant |-> (wip && !$past(wip)));
endmodule

// File: rtl/flash_status_prot.sv
module flash_status_prot
  import flash_sr_pkg::*;
#(
  parameter int SECTORS           = 32,
  parameter int PROG_CYCLES       = 8,
  parameter int SECT_ERASE_CYCLES = 20,
  parameter int BULK_ERASE_CYCLES = 40,
  parameter int STATUS_WR_CYCLES  = 6,
  localparam int SECT_W = $clog2(SECTORS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic              cmdWrDis,
  input  logic              cmdWrStat,
  input  logic              cmdProg,
  input  logic              cmdSecErase,
  input  logic              cmdBulkErase,
  input  logic [SECT_W-1:0] cmdSector,
  input  logic [BP_W-1:0]   newProt,
  output logic [7:0]        statusOut,
  output logic              opGrant,
  output logic              opRefuse
);
  srStrobe_t strb;
  logic wel, wip, bpAny, sectorLocked;

  flash_sr_ctrl #(
    .PROG_CYCLES(PROG_CYCLES), .SECT_ERASE_CYCLES(SECT_ERASE_CYCLES),
    .BULK_ERASE_CYCLES(BULK_ERASE_CYCLES), .STATUS_WR_CYCLES(STATUS_WR_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdWrEn(cmdWrEn), .cmdWrDis(cmdWrDis), .cmdWrStat(cmdWrStat),
    .cmdProg(cmdProg), .cmdSecErase(cmdSecErase), .cmdBulkErase(cmdBulkErase),
    .wel(wel), .wip(wip), .bpAny(bpAny), .sectorLocked(sectorLocked),
    .strb(strb), .opGrant(opGrant), .opRefuse(opRefuse)
  );

  flash_sr_dp #(.SECTORS(SECTORS)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .newProt(newProt), .sector(cmdSector),
    .wel(wel), .wip(wip), .bpAny(bpAny), .sectorLocked(sectorLocked),
    .statusOut(statusOut)
  );
endmodule

// File: tb/tb_flash_status_prot.sv
`timescale 1ns/1ps
module tb_flash_status_prot;
  localparam int NSEC = 32;
  localparam int LPROG = 3, LSECT = 5, LBULK = 7, LWRSR = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdWrEn = 0, cmdWrDis = 0, cmdWrStat = 0, cmdProg = 0, cmdSecErase = 0, cmdBulkErase = 0;
  logic [4:0] cmdSector = '0;
  logic [2:0] newProt = '0;
  logic [7:0] statusOut;
  logic opGrant, opRefuse;

  int checks = 0, fails = 0;
  string curReq = "R1";

  flash_status_prot #(.SECTORS(NSEC), .PROG_CYCLES(LPROG), .SECT_ERASE_CYCLES(LSECT),
    .BULK_ERASE_CYCLES(LBULK), .STATUS_WR_CYCLES(LWRSR)) dut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrDis(cmdWrDis), .cmdWrStat(cmdWrStat),
    .cmdProg(cmdProg), .cmdSecErase(cmdSecErase), .cmdBulkErase(cmdBulkErase),
    .cmdSector(cmdSector), .newProt(newProt), .statusOut(statusOut),
    .opGrant(opGrant), .opRefuse(opRefuse));

  always #5 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int mWel, mWip, mBp, mLeft, mGrant, mRefuse;

  function automatic int lockedCount(int code);
    if (code == 0) return 0;
    if (code <= 5) return NSEC >> (6 - code);
    return NSEC;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mWel = 0; mWip = 0; mBp = 0; mLeft = 0; mGrant = 0; mRefuse = 0;
    end else begin
      mGrant = 0; mRefuse = 0;
      if (mWip != 0) begin
        mLeft--;
        if (mLeft == 0) begin mWip = 0; mWel = 0; end
      end else if (cmdBulkErase) begin
        if (mWel == 0) mRefuse = 1;
        else if (mBp != 0) begin mRefuse = 1; mWel = 0; end
        else begin mGrant = 1; mWip = 1; mLeft = LBULK; end
      end else if (cmdSecErase || cmdProg) begin
        if (mWel == 0) mRefuse = 1;
        else if (int'(cmdSector) >= NSEC - lockedCount(mBp)) begin mRefuse = 1; mWel = 0; end
        else begin mGrant = 1; mWip = 1; mLeft = cmdSecErase ? LSECT : LPROG; end
      end else if (cmdWrStat) begin
        if (mWel == 0) mRefuse = 1;
        else begin mGrant = 1; mWip = 1; mLeft = LWRSR; mBp = int'(newProt); end
      end else if (cmdWrDis) mWel = 0;
      else if (cmdWrEn) mWel = 1;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rstN) begin
      check({curReq, " status"}, int'(statusOut), (mBp << 2) | (mWel << 1) | mWip);
      check({curReq, " grant"}, int'(opGrant), mGrant);
      check({curReq, " refuse"}, int'(opRefuse), mRefuse);
    end
  end

  task automatic ev(input logic en, dis, wst, prg, se, be, input int sec, input int prot);
    @(negedge clk);
    cmdWrEn = en; cmdWrDis = dis; cmdWrStat = wst; cmdProg = prg;
    cmdSecErase = se; cmdBulkErase = be; cmdSector = 5'(sec); newProt = 3'(prot);
    @(negedge clk);
    cmdWrEn = 0; cmdWrDis = 0; cmdWrStat = 0; cmdProg = 0; cmdSecErase = 0; cmdBulkErase = 0;
  endtask

  task automatic waitIdle();
    while (statusOut[0]) @(negedge clk);
  endtask

  task automatic setProt(int code);
    ev(1,0,0,0,0,0,0,0);
    ev(0,0,1,0,0,0,0,code);
    waitIdle();
  endtask

  initial begin
    #(10 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    curReq = "R1";
    check("R1 reset status", int'(statusOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    curReq = "R3";
    ev(0,0,0,1,0,0,0,0);
    check("R3 refuse without latch", int'(opRefuse), 1);
    check("R3 status unchanged", int'(statusOut), 0);
    ev(0,0,1,0,0,0,0,5);
    check("R3 status write refused", int'(statusOut), 0);

    curReq = "R2";
    ev(1,0,0,0,0,0,0,0);
    check("R2 latch set", int'(statusOut[1]), 1);
    ev(0,1,0,0,0,0,0,0);
    check("R2 latch clear", int'(statusOut[1]), 0);

    curReq = "R4";
    ev(1,0,0,0,0,0,0,0);
    ev(0,0,0,1,0,0,3,0);
    check("R11 grant pulse", int'(opGrant), 1);
    n = 0;
    while (statusOut[0]) begin n++; @(negedge clk); end
    check("R4 program length", n, LPROG);
    check("R5 latch cleared at end", int'(statusOut[1]), 0);
    check("R11 grant single cycle", int'(opGrant), 0);

    curReq = "R6";
    ev(1,0,0,0,0,0,0,0);
    ev(0,0,0,0,1,0,2,0);
    ev(0,1,0,0,0,0,0,0);
    check("R6 latch clear ignored while busy", int'(statusOut[1]), 1);
    ev(0,0,0,1,0,0,0,0);
    check("R6 no grant while busy", int'(opGrant), 0);
    check("R6 no refuse while busy", int'(opRefuse), 0);
    waitIdle();

    curReq = "R7";
    setProt(3);
    check("R7 protect loaded", int'(statusOut[4:2]), 3);

    curReq = "R10";
    ev(1,0,0,0,0,0,0,0);
    ev(0,0,0,1,0,0,28,0);
    check("R10 locked refused", int'(opRefuse), 1);
    check("R10 busy stays low", int'(statusOut[0]), 0);
    check("R10 latch cleared", int'(statusOut[1]), 0);
    ev(1,0,0,0,0,0,0,0);
    ev(0,0,0,0,1,0,27,0);
    check("R9 below boundary granted", int'(opGrant), 1);
    waitIdle();

    curReq = "R8";
    ev(1,0,0,0,0,0,0,0);
    ev(0,0,0,0,0,1,0,0);
    check("R8 bulk refused with protect", int'(opRefuse), 1);
    check("R8 latch cleared", int'(statusOut[1]), 0);

    curReq = "R9";
    for (int code = 0; code < 8; code++) begin
      int lo;
      setProt(code);
      lo = NSEC - lockedCount(code);
      if (lo < NSEC) begin
        ev(1,0,0,0,0,0,0,0);
        ev(0,0,0,0,1,0,lo,0);
        check("R9 boundary sector locked", int'(opRefuse), 1);
      end
      if (lo > 0) begin
        ev(1,0,0,0,0,0,0,0);
        ev(0,0,0,0,1,0,lo-1,0);
        check("R9 sector below boundary open", int'(opGrant), 1);
        waitIdle();
      end
    end

    curReq = "R8";
    setProt(0);
    ev(1,0,0,0,0,0,0,0);
    ev(0,0,0,0,0,1,0,0);
    n = 0;
    while (statusOut[0]) begin n++; @(negedge clk); end
    check("R8 bulk granted, length", n, LBULK);

    curReq = "R12";
    ev(1,0,0,0,0,0,0,0);
    ev(1,1,0,0,0,0,0,0);
    check("R12 latch clear beats set", int'(statusOut[1]), 0);
    ev(1,0,0,0,0,0,0,0);
    ev(0,0,1,1,1,0,1,6);
    n = 0;
    while (statusOut[0]) begin n++; @(negedge clk); end
    check("R12 sector erase wins", n, LSECT);
    check("R12 status write dropped", int'(statusOut[4:2]), 0);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule